// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Monitor

This block watches a recovered line clock against the local reference clock and reports whether the two agree in frequency. The recovered clock reaches the block already divided down, as a slow square wave. Every rising and every falling edge of that wave counts as one recovered event. The wave is brought into the reference domain through a short flop synchronizer. The block counts events over a gate window made of a whole number of reference cycles. It then compares the count against a band of plus or minus 100 ppm around the nominal value, with a floor of one count.

A rate bit selects the line rate and a two-bit code selects the reference frequency.

- With the rate bit at 0 (155.52 Mbit/s): code 00 is 19.44 MHz, 10 is 77.76 MHz and 11 is 155.52 MHz.
- With the rate bit at 1 (139.264 Mbit/s): 00 is 17.408 MHz and 11 is 139.264 MHz.

The gate window grows with the reference frequency, so it always spans the same time. As a result the nominal count is the same for every supported setting. The loss-of-lock flag rises only after a run of out-of-band windows that exceeds the set time, default about 420 µs. It falls only after a run of in-band windows that exceeds the clear time, default about 500 µs. Any window of the opposite kind restarts the run. An unsupported setting raises a configuration flag and holds loss of lock high.

Top module: `lol_freq_monitor`

## Requirements
- R1: While reset is applied and after it is released, lossOfLock is 1. For a supported setting, invalidCfg is 0.
- R2: The nominal count is E = BASE_GATE*8/REC_DIV and the tolerance is T = max(1, E*TOL_PPM/1e6). A window whose event count lies within E-T..E+T inclusive is in tolerance; any other count is out of tolerance. With the bench values (E=32, T=1), counts 31 and 33 are in tolerance and counts 30 and 34 are out.
- R3: The gate window lasts BASE_GATE*S reference cycles. S is taken from {rateSel, refSel}: 0/00 gives 1, 0/10 gives 4, 0/11 gives 8, 1/00 gives 1 and 1/11 gives 8.
- R4: refSel 01 with either rate, or refSel 10 with rateSel 1, is unsupported. invalidCfg is then 1 within two cycles, and lossOfLock is forced to 1 while the setting stays unsupported.
- R5: lossOfLock rises at the end of the SET_WINDOWS-th consecutive out-of-tolerance window, and at no other window end.
- R6: An in-tolerance window restarts the out-of-tolerance run.
- R7: lossOfLock falls at the end of the CLEAR_WINDOWS-th consecutive in-tolerance window. An out-of-tolerance window restarts that run.
- R8: The first window after reset, or after any change of {rateSel, refSel}, is discarded. A change also restarts the gate and both runs, and it leaves lossOfLock at its current value.
- R9: Each rising or falling edge of recDivIn counts as one event, after passing through SYNC_STAGES flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| recDivIn | input | 1 | Divided recovered clock, asynchronous to clk |
| rateSel | input | 1 | Line rate: 0 = 155.52 Mbit/s, 1 = 139.264 Mbit/s |
| refSel | input | 2 | Reference frequency select code |
| lossOfLock | output | 1 | Frequency lock lost |
| invalidCfg | output | 1 | Unsupported rate/reference setting |

## Verification
The invalidCfg flag and the forced lossOfLock follow a change of setting after two register stages. The bench therefore samples them three cycles after it drives the change.

A window's verdict reaches lossOfLock two cycles after the window closes. Recovered events arrive three cycles after their edge on recDivIn, so the design's windows run a few cycles behind the bench's. For that reason the bench samples lossOfLock only in the middle of each bench window, where it reflects every window that has already closed. The bench keeps every rate step large enough, or runs enough windows after it, that the window straddling the step cannot change the expected value.

// File: rtl/lol_mon_pkg.sv
package lol_mon_pkg;

  // Measurement strobes handed from the datapath to the persistence control.
  typedef struct packed {
    logic winDone;   // a counted (non-priming) window closed this cycle
    logic inTol;     // verdict of the window that closed
    logic restart;   // setting changed, gate restarted
    logic invalid;   // unsupported setting present
  } measStrobe_t;

  // Gate scale for a rate/reference setting; 0 marks an unsupported one.
  function automatic logic [3:0] refScale(input logic rate, input logic [1:0] sel);
    logic [3:0] s;
    case ({rate, sel})
      3'b000:  s = 4'd1;
      3'b010:  s = 4'd4;
      3'b011:  s = 4'd8;
      3'b100:  s = 4'd1;
      3'b111:  s = 4'd8;
      default: s = 4'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lol_edge_sync.sv
module lol_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic recIn,
  output logic eventOut
);

  logic [SYNC_STAGES-1:0] stageQ;
  logic                   lastQ;

  // R9: plain flop chain into the reference domain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[0] <= 1'b0;
        else       stageQ[0] <= recIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[i] <= 1'b0;
        else       stageQ[i] <= stageQ[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= stageQ[SYNC_STAGES-1];
  end

  // Both edges of the divided clock count
  assign eventOut = stageQ[SYNC_STAGES-1] ^ lastQ;

endmodule

// File: rtl/lol_meas_path.sv
module lol_meas_path
  import lol_mon_pkg::*;
#(
  parameter int BASE_GATE = 1024,
  parameter int REC_DIV   = 8,
  parameter int TOL_PPM   = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        eventIn,
  input  logic        rateSel,
  input  logic [1:0]  refSel,
  output measStrobe_t measQ
);

  localparam int     GATE_MAX   = BASE_GATE * 8;
  localparam int     GW         = $clog2(GATE_MAX);
  localparam int     CW         = $clog2(GATE_MAX + 1);
  localparam int     EXPECTED   = GATE_MAX / REC_DIV;
  localparam longint TOL_RAW    = (longint'(EXPECTED) * longint'(TOL_PPM)) / 64'd1000000;
  localparam int     TOL        = (TOL_RAW < 1) ? 1 : int'(TOL_RAW);
  localparam logic [CW-1:0] LOW_C  = CW'(EXPECTED - TOL);
  localparam logic [CW-1:0] HIGH_C = CW'(EXPECTED + TOL);
  localparam logic [GW-1:0] LAST_X1 = GW'(BASE_GATE - 1);
  localparam logic [GW-1:0] LAST_X4 = GW'(4 * BASE_GATE - 1);
  localparam logic [GW-1:0] LAST_X8 = GW'(8 * BASE_GATE - 1);

  logic [2:0]    cfgQ;
  logic          cfgChange;
  logic [3:0]    scale;
  logic          cfgValid;
  logic [GW-1:0] gateLast;
  logic [GW-1:0] gateCnt;
  logic [CW-1:0] evtCnt;
  logic [CW-1:0] totalCount;
  logic          winEnd;
  logic          primed;
  logic          inTolNow;

  // R3 / R4: setting decode
  assign scale     = refScale(rateSel, refSel);
  assign cfgValid  = (scale != 4'd0);
  assign cfgChange = ({rateSel, refSel} != cfgQ);

  always_comb begin
    case (scale)
      4'd1:    gateLast = LAST_X1;
      4'd4:    gateLast = LAST_X4;
      4'd8:    gateLast = LAST_X8;
      default: gateLast = '0;
    endcase
  end

  assign winEnd     = cfgValid && !cfgChange && (gateCnt == gateLast);
  assign totalCount = evtCnt + CW'(eventIn);
  // R2: tolerance band around the nominal count
  assign inTolNow   = (totalCount >= LOW_C) && (totalCount <= HIGH_C);

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= 3'b000;
    else       cfgQ <= {rateSel, refSel};
  end

  // Gate counter: restarts on a setting change, frozen at 0 while unsupported
  always_ff @(posedge clk) begin
    if (!rstN || !cfgValid || cfgChange) gateCnt <= '0;
    else if (gateCnt == gateLast)        gateCnt <= '0;
    else                                 gateCnt <= gateCnt + GW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !cfgValid || cfgChange) evtCnt <= '0;
    else if (winEnd)                     evtCnt <= '0;
    else                                 evtCnt <= totalCount;
  end

  // R8: first window after reset or a change only primes the synchronizer
  always_ff @(posedge clk) begin
    if (!rstN || !cfgValid || cfgChange) primed <= 1'b0;
    else if (winEnd)                     primed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      measQ <= '0;
    end else begin
      measQ.winDone <= winEnd && primed;
      measQ.inTol   <= inTolNow;
      measQ.restart <= cfgChange;
      measQ.invalid <= !cfgValid;
    end
  end

  // R2: no window can hold more events than it has cycles
  a_r2_count_fits_window: assert property (@(posedge clk) disable iff (!rstN)
    winEnd |-> (totalCount <= (CW'(gateLast) + CW'(1))));

endmodule

// File: rtl/lol_persist_ctrl.sv
module lol_persist_ctrl
  import lol_mon_pkg::*;
#(
  parameter int SET_WINDOWS   = 8,
  parameter int CLEAR_WINDOWS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  measStrobe_t meas,
  output logic        lossOfLock,
  output logic        invalidCfg
);

  localparam int BW = $clog2(SET_WINDOWS + 1);
  localparam int KW = $clog2(CLEAR_WINDOWS + 1);
  localparam logic [BW-1:0] SET_LAST = BW'(SET_WINDOWS - 1);
  localparam logic [KW-1:0] CLR_LAST = KW'(CLEAR_WINDOWS - 1);

  logic [BW-1:0] badRun;
  logic [KW-1:0] goodRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lossOfLock <= 1'b1;            // R1
      invalidCfg <= 1'b0;
      badRun     <= '0;
      goodRun    <= '0;
    end else begin
      invalidCfg <= meas.invalid;
      if (meas.invalid) begin        // R4
        lossOfLock <= 1'b1;
        badRun     <= '0;
        goodRun    <= '0;
      end else if (meas.restart) begin  // R8
        badRun     <= '0;
        goodRun    <= '0;
      end else if (meas.winDone) begin
        if (meas.inTol) begin
          badRun <= '0;              // R6
          if (goodRun >= CLR_LAST) lossOfLock <= 1'b0;  // R7
          else                     goodRun    <= goodRun + KW'(1);
        end else begin
          goodRun <= '0;             // R7 run restart
          if (badRun >= SET_LAST) lossOfLock <= 1'b1;   // R5
          else                    badRun     <= badRun + BW'(1);
        end
      end
    end
  end

  a_r5_rise_needs_bad_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossOfLock) |-> $past(meas.invalid || (meas.winDone && !meas.inTol)));

  a_r7_fall_needs_good_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossOfLock) |-> $past(meas.winDone && meas.inTol && !meas.invalid && !meas.restart));

  a_r4_invalid_forces_loss: assert property (@(posedge clk) disable iff (!rstN)
    meas.invalid |=> (lossOfLock && invalidCfg));

  a_r8_restart_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    (meas.restart && !meas.invalid) |=> $stable(lossOfLock));

endmodule

// File: rtl/lol_freq_monitor.sv
module lol_freq_monitor
  import lol_mon_pkg::*;
#(
  parameter int BASE_GATE     = 1024,
  parameter int REC_DIV       = 8,
  parameter int TOL_PPM       = 100,
  parameter int SET_WINDOWS   = 8,
  parameter int CLEAR_WINDOWS = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       recDivIn,
  input  logic       rateSel,
  input  logic [1:0] refSel,
  output logic       lossOfLock,
  output logic       invalidCfg
);

  logic        recEvent;
  measStrobe_t measStrobe;

  lol_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .recIn    (recDivIn),
    .eventOut (recEvent)
  );

  lol_meas_path #(
    .BASE_GATE (BASE_GATE),
    .REC_DIV   (REC_DIV),
    .TOL_PPM   (TOL_PPM)
  ) u_meas (
    .clk     (clk),
    .rstN    (rstN),
    .eventIn (recEvent),
    .rateSel (rateSel),
    .refSel  (refSel),
    .measQ   (measStrobe)
  );

  lol_persist_ctrl #(
    .SET_WINDOWS   (SET_WINDOWS),
    .CLEAR_WINDOWS (CLEAR_WINDOWS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .meas       (measStrobe),
    .lossOfLock (lossOfLock),
    .invalidCfg (invalidCfg)
  );

endmodule

// File: tb/sim_lol_freq_monitor.sv
`timescale 1ns/1ps
module sim_lol_freq_monitor;

  localparam int BASE = 64;
  localparam int NVEC = 19;

  // count per window, windows to run, expected lossOfLock mid last window
  localparam int vecCnt [NVEC] = '{32, 32, 33, 31, 40, 40, 40, 34, 32, 40,
                                   32, 32, 24, 30, 30, 32, 40, 32, 40};
  localparam int vecWin [NVEC] = '{ 4,  1,  4,  4,  1,  2,  1,  6,  3,  1,
                                    4,  1,  1,  3,  4,  5,  2,  1,  2};
  localparam int vecLol [NVEC] = '{ 1,  0,  0,  0,  0,  0,  1,  1,  1,  1,
                                    1,  0,  0,  1,  1,  0,  0,  0,  0};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       recDivIn = 1'b0;
  logic       rateSel = 1'b0;
  logic [1:0] refSel = 2'b00;
  logic       lossOfLock;
  logic       invalidCfg;

  int nChecks = 0;
  int nFails  = 0;
  int acc     = 0;
  logic lolMid;

  always #5 clk = ~clk;

  lol_freq_monitor #(
    .BASE_GATE(BASE), .REC_DIV(16), .TOL_PPM(100),
    .SET_WINDOWS(3), .CLEAR_WINDOWS(4), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rstN(rstN), .recDivIn(recDivIn), .rateSel(rateSel),
    .refSel(refSel), .lossOfLock(lossOfLock), .invalidCfg(invalidCfg)
  );

  function automatic string vecTag(input int i);
    case (i)
      0: return "R7 R1 not yet cleared";
      1: return "R7 R9 cleared";
      2: return "R2 count 33 in band";
      3: return "R2 count 31 in band";
      5: return "R6 R5 two bad windows";
      6: return "R5 set";
      7: return "R2 count 34 out of band";
      10: return "R7 good run restarted";
      11: return "R7 cleared again";
      13: return "R5 set at 30";
      14: return "R2 count 30 out of band";
      15: return "R7 recovered";
      18: return "R6 bad run restarted";
      default: return "R5 R7 sequence";
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, got, exp);
    end
  endtask

  // Run n windows of (BASE*scale) cycles carrying cnt edges each
  task automatic runWindows(input int n, input int cnt, input int scale);
    int w;
    w = BASE * scale;
    acc = 0;
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        acc += cnt;
        if (acc >= w) begin
          acc -= w;
          recDivIn = ~recDivIn;
        end
        if (c == w / 2) lolMid = lossOfLock;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // Reset state (R1)
    repeat (4) @(negedge clk);
    check(lossOfLock, 1'b1, "R1 lossOfLock during reset");
    check(invalidCfg, 1'b0, "R1 invalidCfg during reset");
    rstN = 1'b1;
    // Priming window after reset (R8), then the vector table
    runWindows(1, 32, 1);
    check(lolMid, 1'b1, "R1 lossOfLock held after reset");
    for (int i = 0; i < NVEC; i++) begin
      runWindows(vecWin[i], vecCnt[i], 1);
      check(lolMid, vecLol[i][0], vecTag(i));
    end

    // Unsupported settings (R4)
    refSel = 2'b01;
    idle(3);
    check(invalidCfg, 1'b1, "R4 code 01 flagged");
    check(lossOfLock, 1'b1, "R4 code 01 forces loss");
    rateSel = 1'b1; refSel = 2'b10;
    idle(3);
    check(invalidCfg, 1'b1, "R4 code 10 at rate 1 flagged");
    idle(200);
    check(lossOfLock, 1'b1, "R4 loss held while unsupported");

    // Rate 1, code 00 (R3), priming discarded (R8)
    refSel = 2'b00;
    idle(3);
    check(invalidCfg, 1'b0, "R3 rate 1 code 00 supported");
    runWindows(4, 32, 1);
    check(lolMid, 1'b1, "R8 R3 rate1/00 still locked out");
    runWindows(1, 32, 1);
    check(lolMid, 1'b1, "R8 priming window not counted");
    runWindows(1, 32, 1);
    check(lolMid, 1'b0, "R7 R3 rate1/00 cleared");

    // Rate 1, code 11: window x8 (R3); change keeps flag (R8)
    refSel = 2'b11;
    runWindows(1, 32, 8);
    check(lolMid, 1'b0, "R8 flag kept across change");
    check(invalidCfg, 1'b0, "R3 rate 1 code 11 supported");
    runWindows(3, 40, 8);
    check(lolMid, 1'b0, "R5 R3 two bad x8 windows");
    runWindows(1, 40, 8);
    check(lolMid, 1'b1, "R5 R3 set with x8 window");

    // Rate 0, code 10: window x4 (R3)
    rateSel = 1'b0; refSel = 2'b10;
    runWindows(5, 32, 4);
    check(lolMid, 1'b1, "R8 R3 rate0/10 after three good");
    runWindows(1, 32, 4);
    check(lolMid, 1'b0, "R7 R3 rate0/10 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule